// File: doc/BRIEF.md
# UART Receive Command and FIFO Lock Controller

This block sits behind the serial deserializer of a UART receiver. A host writes one command byte, and that byte can turn the receiver on or off, flush the receive state machine, flush the receive FIFO and lock the FIFO, in any combination. Characters arrive from the deserializer on a valid/data interface. They are stored in a four-entry FIFO. The host reads them through a pop interface that shows the oldest character ahead of the pop.

A lock freezes the FIFO contents. While the lock is set, new characters are dropped and a sticky overrun flag records the loss. The host can still drain the stored characters. Only a flush of the receive machine removes the lock. When a flush and a lock are requested in the same command, the flush wins and the lock request is ignored.

The control state machine has four states:
- `RX_OFF`: disabled, unlocked.
- `RX_ON`: enabled, unlocked.
- `LK_OFF`: disabled, locked.
- `LK_ON`: enabled, locked.

Every command write takes one of four transitions:
- ENABLE: bit 7 set.
- DISABLE: bit 7 clear.
- LOCK: bit 3 set with both flush bits clear.
- UNLOCK: bit 5 set.

ENABLE or DISABLE is combined with LOCK, UNLOCK or hold to choose the next state.

Top module: `rx_cmd_ctrl`

## Requirements
- R1: After reset the block reports the FIFO empty, not full, unlocked, the receiver disabled and no overrun.
- R2: Every command write loads the receiver enable from bit 7 of the byte. While the receiver is disabled, offered characters leave the FIFO and the overrun flag unchanged.
- R3: Command bit 4 empties the FIFO at the write's clock edge, so the empty flag is high on the next cycle. A push or pop in the same cycle is cancelled.
- R4: Command bit 3, with bits 5 and 4 both clear, sets the locked flag on the next cycle.
- R5: Command bit 5 clears the lock and the overrun flag. A lock request in a command that also sets bit 5 or bit 4 is ignored. For example, 0xB8 leaves the receiver enabled, the FIFO empty and unlocked.
- R6: A command with bit 5 clear never clears the lock. Bits 6, 2, 1 and 0 have no effect.
- R7: While the FIFO is locked and the receiver is enabled, offered characters are not stored and set the overrun flag. Pops still return the stored characters.
- R8: The FIFO is first-in first-out. `rx_pop_data` shows the oldest character whenever the FIFO is not empty. A pop removes that character, and a pop on an empty FIFO is ignored.
- R9: The full flag rises after four characters are stored. While the FIFO is full, characters offered to the enabled receiver are dropped and set the overrun flag.
- R10: The full and empty flags come from registers and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| rx_valid | input | 1 | Deserialized character valid |
| rx_char | input | 8 | Deserialized character |
| rx_pop | input | 1 | Host pop request |
| rx_pop_data | output | 8 | Oldest stored character |
| fifo_empty | output | 1 | FIFO holds no character |
| fifo_full | output | 1 | FIFO holds four characters |
| fifo_locked | output | 1 | FIFO lock flag |
| rx_enabled | output | 1 | Receiver enable state |
| rx_overrun | output | 1 | Sticky flag set when a character is lost |

## Verification
Several properties are checked by assertions on every cycle:
- A rise of the lock follows a lock-only command.
- A fall of the lock follows a machine flush.
- A FIFO flush leaves the FIFO empty.
- The full and empty flags never coincide.
- A disabled, idle receiver keeps an empty FIFO empty.

The following can only be shown by the bench's scenarios, where a queue model predicts every output on every clock:
- The order in which characters come out.
- The 0xB8 conflict resolution.
- Draining the FIFO while it is locked.
- The overrun behaviour at the full boundary.

// File: rtl/rxcmd_pkg.sv
package rxcmd_pkg;

    // Command byte bit positions
    localparam int unsigned CMD_W      = 8;
    localparam int unsigned BIT_ENABLE = 7;
    localparam int unsigned BIT_FLUSHM = 5;
    localparam int unsigned BIT_FLUSHF = 4;
    localparam int unsigned BIT_LOCK   = 3;

    typedef struct packed {
        logic enable;
        logic flush_mach;
        logic flush_fifo;
        logic lock_req;
    } rxcmd_t;

    typedef enum logic [1:0] {
        RX_OFF = 2'b00,
        RX_ON  = 2'b01,
        LK_OFF = 2'b10,
        LK_ON  = 2'b11
    } rxst_e;

endpackage

// File: rtl/rxcmd_decode.sv
module rxcmd_decode
    import rxcmd_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_byte,
    output rxcmd_t           cmd
);
    // Reserved bits are deliberately not used
    logic unused_rsvd;
    assign unused_rsvd = ^{cmd_byte[6], cmd_byte[2:0]};

    always_comb begin
        cmd.enable     = cmd_byte[BIT_ENABLE];
        cmd.flush_mach = cmd_byte[BIT_FLUSHM];
        cmd.flush_fifo = cmd_byte[BIT_FLUSHF];
        // a lock written together with any flush is dropped
        cmd.lock_req   = cmd_byte[BIT_LOCK]
                         & ~cmd_byte[BIT_FLUSHM]
                         & ~cmd_byte[BIT_FLUSHF];
    end
endmodule

// File: rtl/rxcmd_fsm.sv
module rxcmd_fsm
    import rxcmd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_we,
    input  rxcmd_t cmd,
    input  logic   drop,
    output logic   enabled,
    output logic   locked,
    output logic   overrun
);
    rxst_e state_q, state_d;

    function automatic rxst_e pick(input logic lk, input logic en);
        rxst_e r;
        unique case ({lk, en})
            2'b00:   r = RX_OFF;
            2'b01:   r = RX_ON;
            2'b10:   r = LK_OFF;
            default: r = LK_ON;
        endcase
        return r;
    endfunction

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (cmd_we) begin
            unique case (state_q)
                RX_OFF, RX_ON: begin
                    // LOCK or hold, combined with ENABLE/DISABLE
                    state_d = pick(cmd.lock_req, cmd.enable);
                end
                LK_OFF, LK_ON: begin
                    // UNLOCK only through a machine flush
                    state_d = pick(~cmd.flush_mach, cmd.enable);
                end
                default: state_d = RX_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_OFF;
        else        state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            RX_OFF:  begin enabled = 1'b0; locked = 1'b0; end
            RX_ON:   begin enabled = 1'b1; locked = 1'b0; end
            LK_OFF:  begin enabled = 1'b0; locked = 1'b1; end
            LK_ON:   begin enabled = 1'b1; locked = 1'b1; end
            default: begin enabled = 1'b0; locked = 1'b0; end
        endcase
    end

    // sticky overrun; machine flush has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                        overrun <= 1'b0;
        else if (cmd_we && cmd.flush_mach) overrun <= 1'b0;
        else if (drop)                     overrun <= 1'b1;
    end

    // R4
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cmd_we && cmd.lock_req));

    // R5
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(cmd_we && cmd.flush_mach));

    // R5
    flush_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd.flush_mach) |=> (!locked && !overrun));
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count, count_d;
    logic             do_push, do_pop;

    // flush cancels any push or pop in the same cycle
    assign do_push = push && !full  && !flush;
    assign do_pop  = pop  && !empty && !flush;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr == PTR_W'(g)) mem[g] <= din;
        end
    end

    always_comb begin
        count_d = count;
        if (flush) count_d = '0;
        else begin
            unique case ({do_push, do_pop})
                2'b10:   count_d = count + 1'b1;
                2'b01:   count_d = count - 1'b1;
                default: count_d = count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            empty <= 1'b1;
            full  <= 1'b0;
        end else begin
            count <= count_d;
            empty <= (count_d == '0);
            full  <= (count_d == FULL_CNT);
        end
    end

    assign dout = mem[rd_ptr];

    // R10
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

    // R8
    empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);
endmodule

// File: rtl/rx_cmd_ctrl.sv
module rx_cmd_ctrl
    import rxcmd_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_byte,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_pop,
    output logic [CHAR_W-1:0] rx_pop_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              fifo_locked,
    output logic              rx_enabled,
    output logic              rx_overrun
);
    rxcmd_t cmd;
    logic   accept, drop, flush_fifo;

    rxcmd_decode u_dec (
        .cmd_byte (cmd_byte),
        .cmd      (cmd)
    );

    assign flush_fifo = cmd_we && cmd.flush_fifo;
    assign accept     = rx_valid && rx_enabled && !fifo_locked && !fifo_full;
    assign drop       = rx_valid && rx_enabled && (fifo_locked || fifo_full);

    rxcmd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_we  (cmd_we),
        .cmd     (cmd),
        .drop    (drop),
        .enabled (rx_enabled),
        .locked  (fifo_locked),
        .overrun (rx_overrun)
    );

    rx_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_fifo),
        .push  (accept),
        .din   (rx_char),
        .pop   (rx_pop),
        .dout  (rx_pop_data),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    // R2
    disabled_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enabled && fifo_empty && !cmd_we) |=> fifo_empty);

    // R7
    locked_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_locked && fifo_empty && !cmd_we) |=> fifo_empty);
endmodule

// File: tb/rx_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module rx_cmd_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = 8'h00;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_pop_data;
    logic       fifo_empty, fifo_full, fifo_locked, rx_enabled, rx_overrun;

    always #2.5 clk = ~clk;

    rx_cmd_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .cmd_we (cmd_we), .cmd_byte (cmd_byte),
        .rx_valid (rx_valid), .rx_char (rx_char), .rx_pop (rx_pop),
        .rx_pop_data (rx_pop_data), .fifo_empty (fifo_empty),
        .fifo_full (fifo_full), .fifo_locked (fifo_locked),
        .rx_enabled (rx_enabled), .rx_overrun (rx_overrun)
    );

    int     n_vec = 0;
    int     n_bad = 0;
    bit     done = 0;
    string  req = "R1";

    // reference model state
    logic [7:0] q[$];
    bit m_en = 0, m_lock = 0, m_ovr = 0;

    task automatic cmp(input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        cmp("empty",   fifo_empty,  q.size() == 0);
        cmp("full",    fifo_full,   q.size() == 4);
        cmp("locked",  fifo_locked, m_lock);
        cmp("enabled", rx_enabled,  m_en);
        cmp("overrun", rx_overrun,  m_ovr);
        if (q.size() != 0) cmp("pop_data", rx_pop_data, q[0]);
    endtask

    task automatic model_update();
        bit fm, ff, lk, full_pre, acc, drp, pp;
        fm = cmd_we && cmd_byte[5];
        ff = cmd_we && cmd_byte[4];
        lk = cmd_we && cmd_byte[3] && !cmd_byte[5] && !cmd_byte[4];
        full_pre = (q.size() >= 4);
        acc = rx_valid && m_en && !m_lock && !full_pre && !ff;
        drp = rx_valid && m_en && (m_lock || full_pre);
        pp  = rx_pop && q.size() > 0 && !ff;
        if (pp)  void'(q.pop_front());
        if (acc) q.push_back(rx_char);
        if (ff)  q.delete();
        if (fm) m_ovr = 0; else if (drp) m_ovr = 1;
        if (fm && m_lock) m_lock = 0; else if (lk) m_lock = 1;
        if (cmd_we) m_en = cmd_byte[7];
    endtask

    task automatic step(input bit we, input logic [7:0] c, input bit v,
                        input logic [7:0] d, input bit p);
        cmd_we = we; cmd_byte = c; rx_valid = v; rx_char = d; rx_pop = p;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic cmd(input logic [7:0] c);
        step(1, c, 0, 8'h00, 0);
    endtask
    task automatic push(input logic [7:0] d);
        step(0, 8'h00, 1, d, 0);
    endtask
    task automatic popc();
        step(0, 8'h00, 0, 8'h00, 1);
    endtask
    task automatic idle();
        step(0, 8'h00, 0, 8'h00, 0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        req = "R1"; compare_all();
        // R2 disabled receiver discards characters
        req = "R2"; push(8'h11); idle();
        // R2 enable with bit 7, R8 ordering
        cmd(8'h80);
        req = "R8";
        push(8'hA1); push(8'hA2); push(8'hA3);
        popc(); popc(); popc();
        popc(); // pop on empty ignored
        // R9 fill, then overflow
        req = "R9";
        push(8'hB1); push(8'hB2); push(8'hB3); push(8'hB4);
        push(8'hB5); idle();
        // simultaneous push and pop while not full
        req = "R8"; popc(); step(0, 8'h00, 1, 8'hB6, 1); idle();
        // R5 combined 0xB8: flush wins over lock
        req = "R5"; cmd(8'hB8); idle();
        // R4 lock alone
        req = "R4"; push(8'hC1); push(8'hC2); cmd(8'h88); idle();
        // R7 locked: drops set overrun, pops still drain
        req = "R7"; push(8'hC3); popc(); idle();
        // R6 no-flush command keeps lock, reserved bits ignored
        req = "R6"; cmd(8'h80); cmd(8'hC7); push(8'hC4); idle();
        // R3 FIFO flush with lock request and lock held; push/pop cancelled
        req = "R3"; cmd(8'h98); idle();
        // R5 machine flush unlocks and clears overrun
        req = "R5"; cmd(8'hA0); idle();
        // R3 flush cancels same-cycle push and pop
        req = "R3"; push(8'hD1); push(8'hD2);
        step(1, 8'h90, 1, 8'hD3, 1); idle();
        // R2 disable via bit 7 clear, characters discarded
        req = "R2"; push(8'hE1); cmd(8'h08); push(8'hE2); idle(); popc();
        // R5 machine flush alone unlocks when disabled
        req = "R5"; cmd(8'h20); idle();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule